// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell Array

This block is a small programmable logic device built in ordinary synthesizable logic. A bank of configuration registers holds a programmable AND plane. Each product term can take any array column in true form, in complemented form, or not at all. Every output macrocell owns a fixed group of eight product terms, and these feed a hard-wired OR. Global mode bits place all macrocells in one of three behaviours: plain combinational drive, tristate drive with a product-term enable, or a registered drive through a D flip-flop.

The array has sixteen columns. Eight come from dedicated inputs. The other eight come from the macrocell pins, one column per pin. A per-pin direction bit can turn any pin into an input, and its pin value then feeds its column. Each macrocell also has a polarity bit that can invert its OR result. Software loads the configuration one word at a time through a parallel address/data/write-enable port while the device is idle. Setting a done flag in the control word activates the outputs.

Top module: `plcell_array`

## Requirements
- R1: A synchronous active-high reset clears every term mask to 0. It also clears the whole control word, which leaves the device not done and in registered mode, and it clears all macrocell flip-flops. All pin output enables are then 0.
- R2: Addresses 0 to 63 hold term masks, with macrocell = addr[5:3] and term = addr[2:0]. Address 64 holds the control word: bit 0 sync, bit 1 mux, bits 15:8 per-pin input select, bits 23:16 per-macrocell polarity, bit 31 done. Writes to addresses 65 to 127 have no effect.
- R3: In a term mask, bit c (0..15) selects column c in true form and bit 16+c selects it in complemented form. Columns 0 to 7 are ded_in[7:0], and column 8+n is the feedback of macrocell n. A term is the AND of its selected literals, so an empty mask gives 1 and a mask with both polarities of one column gives 0.
- R4: A term-mask write is ignored while done is 1. A term-mask write is accepted while done is 0. A control-word write is always accepted.
- R5: While done is 0, every pin_oe bit is 0.
- R6: When the input-select bit of pin n is 1, pin_oe[n] is 0 and column 8+n carries pin_in[n].
- R7: When the input-select bit of pin n is 0, column 8+n carries the flip-flop of macrocell n.
- R8: In simple mode (sync=1, mux=0) with done=1, each output pin has pin_oe=1 and pin_out equal to the polarity bit XOR the OR of all eight of its terms.
- R9: In complex mode (sync=1, mux=1) with done=1, an output pin's pin_oe equals its term 0, and pin_out equals the polarity bit XOR the OR of terms 1 to 7.
- R10: In registered mode (sync=0) with done=1, each flip-flop loads the polarity bit XOR the OR of all eight terms on every rising clock edge. Output pins drive pin_oe=1 and pin_out equal to the flip-flop. In any other mode, or while done is 0, the flip-flops are cleared to 0.
- R11: When a macrocell's polarity bit is 1, its OR result is inverted in every mode before it reaches the pin or the flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store and the macrocell flip-flops |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration word data |
| ded_in | input | 8 | Dedicated array inputs, columns 0 to 7 |
| pin_in | input | 8 | Values seen on the macrocell pins |
| pin_out | output | 8 | Drive value of each macrocell pin |
| pin_oe | output | 8 | Output enable of each macrocell pin |

## Verification
The assertions check several rules on every cycle. Pins stay undriven while the device is not done, and a pin selected as an input never has its enable set. Term masks hold still after a write that arrives while done is set. Each flip-flop either loads its sum or clears, depending on the mode. Whether the sums are correct is shown only by the bench's scenarios. These cover literal polarity, empty and contradictory terms, feedback through pins and flip-flops, the enable term in complex mode, polarity inversion and the ignored addresses. The bench compares the pins against a model built from the requirements, over changing input patterns in each mode.

// File: rtl/plcell_pkg.sv
package plcell_pkg;

    localparam int N_DED       = 8;
    localparam int N_MC        = 8;
    localparam int N_TERM      = 8;
    localparam int N_COL       = N_DED + N_MC;
    localparam int W_MASK      = 2 * N_COL;
    localparam int N_TERMS_ALL = N_MC * N_TERM;
    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 32;
    localparam int IDX_W       = $clog2(N_TERMS_ALL);
    localparam int CTRL_ADDR   = N_TERMS_ALL;

    // control word field positions
    localparam int CB_SYNC = 0;
    localparam int CB_MUX  = 1;
    localparam int CB_DIR  = 8;
    localparam int CB_POL  = 16;
    localparam int CB_DONE = 31;

    typedef logic [W_MASK-1:0] mask_t;
    typedef logic [N_COL-1:0]  col_t;

    typedef enum logic [1:0] {
        MODE_REG     = 2'b00,
        MODE_SIMPLE  = 2'b01,
        MODE_COMPLEX = 2'b10
    } mode_e;

    typedef struct packed {
        logic            done;
        logic [N_MC-1:0] pol;
        logic [N_MC-1:0] dir_in;
        logic            mux;
        logic            sync;
    } ctrl_t;

    function automatic mode_e mode_of(input logic sync, input logic mux);
        if (!sync)
            return MODE_REG;
        else if (mux)
            return MODE_COMPLEX;
        else
            return MODE_SIMPLE;
    endfunction

    // a literal blocks the term only when selected and false
    function automatic logic eval_term(input mask_t m, input col_t c);
        mask_t lits;
        lits = {~c, c};
        return &(~m | lits);
    endfunction

endpackage

// File: rtl/plcell_cfg.sv
module plcell_cfg
    import plcell_pkg::*;
#(
    parameter int TERMS = N_TERMS_ALL,
    parameter int MW    = W_MASK,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [AW-1:0]             cfg_addr,
    input  logic [DW-1:0]             cfg_wdata,
    output logic [TERMS-1:0][MW-1:0]  masks,
    output ctrl_t                     ctrl
);
    localparam int IW = $clog2(TERMS);

    logic [TERMS-1:0][MW-1:0] mask_q;
    ctrl_t                    ctrl_q;
    logic                     hit_term;
    logic                     hit_ctrl;
    logic [IW-1:0]            idx;

    assign hit_term = cfg_we && (cfg_addr < AW'(TERMS));
    assign hit_ctrl = cfg_we && (cfg_addr == AW'(TERMS));
    assign idx      = cfg_addr[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (hit_term && !ctrl_q.done)
                mask_q[idx] <= cfg_wdata[MW-1:0];
            if (hit_ctrl) begin
                ctrl_q.sync   <= cfg_wdata[CB_SYNC];
                ctrl_q.mux    <= cfg_wdata[CB_MUX];
                ctrl_q.dir_in <= cfg_wdata[CB_DIR +: N_MC];
                ctrl_q.pol    <= cfg_wdata[CB_POL +: N_MC];
                ctrl_q.done   <= cfg_wdata[CB_DONE];
            end
        end
    end

    assign masks = mask_q;
    assign ctrl  = ctrl_q;

    // R4: the AND plane is frozen once done is set
    assert_locked_masks_R4: assert property (@(posedge clk) disable iff (rst)
        (hit_term && ctrl_q.done) |=> $stable(mask_q));

    // R1: reset leaves the control word cleared
    assert_reset_ctrl_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0));

endmodule

// File: rtl/plcell_and_plane.sv
module plcell_and_plane
    import plcell_pkg::*;
#(
    parameter int TERMS = N_TERMS_ALL,
    parameter int MW    = W_MASK,
    parameter int NC    = N_COL
) (
    input  logic [NC-1:0]             cols,
    input  logic [TERMS-1:0][MW-1:0]  masks,
    output logic [TERMS-1:0]          terms
);
    for (genvar g = 0; g < TERMS; g++) begin : g_term
        assign terms[g] = eval_term(masks[g], cols);
    end
endmodule

// File: rtl/plcell_macrocell.sv
module plcell_macrocell
    import plcell_pkg::*;
#(
    parameter int NT = N_TERM
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_e         mode,
    input  logic          done,
    input  logic          dir_in,
    input  logic          pol,
    input  logic [NT-1:0] terms,
    output logic          q,
    output logic          out,
    output logic          oe
);
    logic sum_all;
    logic sum_data;
    logic d;

    assign sum_all  = |terms;
    assign sum_data = |terms[NT-1:1];
    assign d        = pol ^ sum_all;

    always_ff @(posedge clk) begin
        if (rst || !done || (mode != MODE_REG))
            q <= 1'b0;
        else
            q <= d;
    end

    always_comb begin
        out = 1'b0;
        oe  = 1'b0;
        unique case (mode)
            MODE_SIMPLE: begin
                out = d;
                oe  = 1'b1;
            end
            MODE_COMPLEX: begin
                out = pol ^ sum_data;
                oe  = terms[0];
            end
            default: begin
                out = q;
                oe  = 1'b1;
            end
        endcase
        if (!done || dir_in)
            oe = 1'b0;
    end

    // R10: the flip-flop loads the sum in registered mode
    assert_reg_load_R10: assert property (@(posedge clk) disable iff (rst)
        (done && mode == MODE_REG) |=> (q == $past(d)));

    // R10: the flip-flop is cleared outside registered operation
    assert_reg_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (!done || mode != MODE_REG) |=> !q);

endmodule

// File: rtl/plcell_array.sv
module plcell_array
    import plcell_pkg::*;
#(
    parameter int ND = N_DED,
    parameter int NM = N_MC,
    parameter int NT = N_TERM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ND-1:0]     ded_in,
    input  logic [NM-1:0]     pin_in,
    output logic [NM-1:0]     pin_out,
    output logic [NM-1:0]     pin_oe
);
    localparam int TERMS = NM * NT;
    localparam int NC    = ND + NM;
    localparam int MW    = 2 * NC;

    logic [TERMS-1:0][MW-1:0] masks;
    ctrl_t                    ctrl;
    mode_e                    mode;
    logic [NM-1:0]            fb;
    logic [NM-1:0]            q;
    logic [NC-1:0]            cols;
    logic [TERMS-1:0]         terms;

    plcell_cfg #(
        .TERMS(TERMS), .MW(MW), .AW(ADDR_W), .DW(DATA_W)
    ) cfg_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .masks(masks), .ctrl(ctrl)
    );

    assign mode = mode_of(ctrl.sync, ctrl.mux);
    assign cols = {fb, ded_in};

    plcell_and_plane #(
        .TERMS(TERMS), .MW(MW), .NC(NC)
    ) plane_i (
        .cols(cols), .masks(masks), .terms(terms)
    );

    for (genvar i = 0; i < NM; i++) begin : g_mc
        assign fb[i] = ctrl.dir_in[i] ? pin_in[i] : q[i];

        plcell_macrocell #(.NT(NT)) mc_i (
            .clk(clk), .rst(rst), .mode(mode), .done(ctrl.done),
            .dir_in(ctrl.dir_in[i]), .pol(ctrl.pol[i]),
            .terms(terms[i*NT +: NT]),
            .q(q[i]), .out(pin_out[i]), .oe(pin_oe[i])
        );
    end

    // R5: nothing is driven before configuration completes
    assert_idle_tristate_R5: assert property (@(posedge clk) disable iff (rst)
        !ctrl.done |-> (pin_oe == '0));

    // R6: a pin used as an input is never driven
    assert_input_undriven_R6: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ctrl.dir_in) == '0));

    // R1: after reset no pin is driven
    assert_reset_oe_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0));

endmodule

// File: tb/plcell_array_tb_top.sv
module plcell_array_tb_top;
    import plcell_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [6:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [7:0]  ded_in;
    logic [7:0]  pin_in;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    always #5 clk = ~clk;

    plcell_array dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ded_in(ded_in), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    // ---------------- requirement model ----------------
    logic [31:0] m_mask [64];
    logic        m_sync, m_mux, m_done;
    logic [7:0]  m_dir, m_pol, m_q;

    function automatic logic m_col(int c);
        if (c < 8) return ded_in[c];
        return m_dir[c-8] ? pin_in[c-8] : m_q[c-8];
    endfunction

    function automatic logic m_term(int mc, int t);
        logic r;
        r = 1'b1;
        for (int c = 0; c < 16; c++) begin
            if (m_mask[mc*8+t][c] && !m_col(c)) r = 1'b0;
            if (m_mask[mc*8+t][16+c] && m_col(c)) r = 1'b0;
        end
        return r;
    endfunction

    function automatic logic m_or(int mc, int first);
        logic r;
        r = 1'b0;
        for (int t = first; t < 8; t++) r = r | m_term(mc, t);
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < 64; a++) m_mask[a] <= '0;
            {m_sync, m_mux, m_done} <= '0;
            m_dir <= '0; m_pol <= '0; m_q <= '0;
        end else begin
            for (int i = 0; i < 8; i++)
                m_q[i] <= (m_done && !m_sync) ? (m_pol[i] ^ m_or(i, 0)) : 1'b0;
            if (cfg_we) begin
                if (cfg_addr < 7'd64 && !m_done)
                    m_mask[cfg_addr[5:0]] <= cfg_wdata;
                else if (cfg_addr == 7'd64) begin
                    m_sync <= cfg_wdata[0];
                    m_mux  <= cfg_wdata[1];
                    m_dir  <= cfg_wdata[15:8];
                    m_pol  <= cfg_wdata[23:16];
                    m_done <= cfg_wdata[31];
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        string      tag;
        logic [7:0] oe;
        logic [7:0] out;
    } item_t;
    item_t sbq[$];

    task automatic push_expect(string tag);
        item_t it;
        it.tag = tag;
        for (int i = 0; i < 8; i++) begin
            it.oe[i]  = 1'b0;
            it.out[i] = 1'b0;
            if (m_done && !m_dir[i]) begin
                if (!m_sync) begin
                    it.oe[i] = 1'b1; it.out[i] = m_q[i];
                end else if (!m_mux) begin
                    it.oe[i] = 1'b1; it.out[i] = m_pol[i] ^ m_or(i, 0);
                end else begin
                    it.oe[i] = m_term(i, 0); it.out[i] = m_pol[i] ^ m_or(i, 1);
                end
            end
        end
        sbq.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (pin_oe !== it.oe || ((pin_out ^ it.out) & it.oe) != 8'h00) begin
                errors++;
                $display("FAIL %s: oe=%b out=%b expected oe=%b out=%b",
                         it.tag, pin_oe, pin_out, it.oe, it.out);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic drive(string tag, logic [7:0] d, logic [7:0] p);
        @(posedge clk); #1;
        cfg_we = 1'b0; ded_in = d; pin_in = p;
        push_expect(tag);
    endtask

    task automatic cfg_write(logic [6:0] a, logic [31:0] w);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
    endtask

    function automatic logic [31:0] lt(int c); return 32'h1 << c; endfunction
    function automatic logic [31:0] lf(int c); return 32'h1 << (16 + c); endfunction

    function automatic logic [31:0] ctrlw(bit sync, bit mux, logic [7:0] dir,
                                          logic [7:0] pol, bit done);
        return {done, 7'b0, pol, dir, 6'b0, mux, sync};
    endfunction

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        ded_in = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        drive("R1 reset state", 8'h00, 8'h00);
        #1 rst = 1'b0;
        drive("R5 idle after reset", 8'hFF, 8'hFF);

        // R2 R3: every term a contradiction first
        for (int a = 0; a < 64; a++) cfg_write(7'(a), lt(0) | lf(0));
        cfg_write(7'd0,  lt(0) | lt(1));        // mc0 t0 = in0 & in1
        cfg_write(7'd8,  lf(2));                // mc1 t0 = ~in2
        cfg_write(7'd9,  lt(3));                // mc1 t1 = in3
        cfg_write(7'd16, 32'h0);                // mc2 t0 empty -> 1
        cfg_write(7'd24, lt(4));                // mc3 t0 = in4, inverted
        cfg_write(7'd32, lt(5));                // mc4 t0 = in5 (enable)
        cfg_write(7'd33, lt(6));                // mc4 t1 = in6
        cfg_write(7'd48, lt(13));               // mc6 t0 = pin5 column
        cfg_write(7'd49, lt(7) | lf(0));        // mc6 t1 = in7 & ~in0
        cfg_write(7'd56, lf(15));               // mc7 t0 = ~feedback7
        drive("R5 idle during load", 8'hFF, 8'h00);
        cfg_write(7'd64, ctrlw(1, 0, 8'h20, 8'h08, 1));

        for (int k = 0; k < 14; k++)
            drive("R8 R3 R6 R11 simple", 8'(k * 37 + 11), 8'(k * 91 + 3));

        // R4: term writes ignored once done
        cfg_write(7'd0, 32'h0);
        drive("R4 locked write", 8'h00, 8'h00);
        drive("R4 locked write", 8'h02, 8'h00);
        // R2: unmapped address has no effect
        cfg_write(7'd100, 32'hFFFF_FFFF);
        drive("R2 unmapped write", 8'h03, 8'h20);
        drive("R2 unmapped write", 8'h10, 8'h00);

        cfg_write(7'd64, ctrlw(1, 1, 8'h20, 8'h08, 1));
        for (int k = 0; k < 12; k++)
            drive("R9 R11 complex", 8'(k * 53 + 7), 8'(k * 29 + 1));

        cfg_write(7'd64, ctrlw(0, 0, 8'h20, 8'h08, 1));
        for (int k = 0; k < 12; k++)
            drive("R10 R7 registered", 8'(k * 71 + 5), 8'(k * 13 + 32));

        cfg_write(7'd64, ctrlw(1, 0, 8'h20, 8'h08, 0));
        drive("R5 done cleared", 8'hFF, 8'hFF);
        drive("R10 flops cleared", 8'hFF, 8'hFF);
        cfg_write(7'd0, 32'h0);                 // R4: accepted while idle
        cfg_write(7'd64, ctrlw(1, 0, 8'h00, 8'h00, 1));
        drive("R4 unlocked write", 8'h00, 8'h00);
        drive("R6 R7 pin as output", 8'h55, 8'hAA);

        @(posedge clk); #1 rst = 1'b1;
        drive("R1 mid-run reset", 8'hFF, 8'hFF);
        #1 rst = 1'b0;
        drive("R1 after reset", 8'h0F, 8'hF0);

        repeat (3) @(posedge clk);
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!ended) begin
            ended = 1;
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule